// File: doc/BRIEF.md
# Constant-Off-Time Current Limiter

This block regulates the load current of an H-bridge from digital comparator flags. When the current-limit comparator reports an over-threshold current, the block asks the bridge to float both outputs for a fixed number of clock cycles. When that time ends, the commanded drive resumes. Every time one of the bridge outputs switches, a blanking window opens. Inside that window the current-limit comparator is ignored, so that the short-circuit comparator can act first. A short-circuit trip inside the window produces a one-cycle fault pulse, which the surrounding control logic latches.

A hot-die flag from temperature sensing selects a reduced current-limit threshold. The block drives that selection to the analog comparator as a registered signal. All durations are counted in clock cycles and are derived from the clock frequency in MHz. A regulation-rate floor keeps the off-time trigger from repeating faster than a chosen switching rate. Dropping the bridge enable, as a disable or sleep command does, returns every timer to idle.

Top module: `curlim_top`

## Requirements
- R1: While reset is held and on the first cycle after it, force_off, short_fault and thr_low are all 0.
- R2: With the bridge enabled, the timers idle and no blanking active, a sampled lim_trip raises force_off from the next cycle. force_off then stays 1 for exactly CLK_MHZ*OFF_US cycles (2000 with the defaults).
- R3: A lim_trip seen while force_off is 1 neither lengthens nor restarts the off-time.
- R4: A 1 on any bit of out_edge starts the blanking window, or restarts it if it is already running. The window lasts CLK_MHZ*BLANK_US cycles (1600 with the defaults) after the edge that samples the strobe. lim_trip sampled inside it has no effect, and the first lim_trip after it starts an off-time.
- R5: A short_trip sampled inside the blanking window, with the bridge enabled, gives short_fault = 1 for exactly one cycle starting on the next cycle, even if short_trip stays high. A short_trip outside the window gives no pulse.
- R6: thr_low equals the hot_zone value sampled one clock earlier (1 selects the reduced threshold, 0 the normal one).
- R7: Two successive off-time starts are at least CLK_MHZ*1000/RATE_KHZ cycles apart (5000 with the defaults). With lim_trip held high, they are exactly that far apart.
- R8: bridge_en = 0 clears a running off-time on the next cycle and cancels blanking and the rate floor. After bridge_en returns to 1, the next sampled lim_trip starts an off-time at once.
- R9: While bridge_en is 0, lim_trip and short_trip have no effect: force_off and short_fault stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bridge_en | input | 1 | 1 = bridge enabled; 0 = disabled or sleeping, all timers cleared |
| out_edge | input | NOUT | One strobe per bridge output, 1 on a cycle where that output switches |
| lim_trip | input | 1 | Current-limit comparator flag |
| short_trip | input | 1 | Short-circuit comparator flag |
| hot_zone | input | 1 | Die temperature is in the foldback zone |
| force_off | output | 1 | Request to float both bridge outputs |
| short_fault | output | 1 | One-cycle short-circuit detection pulse |
| thr_low | output | 1 | Current-limit threshold select, 1 = reduced |

## Verification
A wrong off-time counter shows up as a force_off pulse of the wrong length. This is visible when the pulse ends, about 2000 cycles after the trip. A wrong rate-floor counter shows up as a second pulse that comes early or late, about 5000 cycles after the first. A blanking counter that is stuck or reloaded badly lets a current-limit trip through too early, or blocks it too long. That shows up within one window length as a force_off that appears off the expected cycle. A broken short-detect edge register shows at once as a missing pulse, or as a pulse that repeats while short_trip stays high.

// File: rtl/curlim_pkg.sv
// Shared helpers for the current limiter: cycle conversions and timer states.
package curlim_pkg;

    // Cycles spanned by a duration in microseconds at a clock in MHz.
    function automatic int unsigned us_to_cycles(input int unsigned mhz, input int unsigned us);
        return mhz * us;
    endfunction

    // Cycles in one period of the maximum regulation rate in kHz.
    function automatic int unsigned rate_to_cycles(input int unsigned mhz, input int unsigned khz);
        return (mhz * 1000) / khz;
    endfunction

    // Off-time sequencer states.
    typedef enum logic [1:0] {
        OT_IDLE = 2'd0,   // ready to accept a trip
        OT_OFF  = 2'd1,   // bridge forced off
        OT_HOLD = 2'd2    // drive resumed, waiting out the rate floor
    } ot_state_e;

endpackage

// File: rtl/curlim_blank.sv
// Blanking window timer.
// Any output-transition strobe loads the counter. The window is active while
// the count is nonzero. Assumes the strobes are synchronous to clk.
module curlim_blank #(
    parameter int unsigned NOUT      = 2,
    parameter int unsigned BLANK_CYC = 1600
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [NOUT-1:0] strobe,
    output logic            blank
);
    localparam int unsigned BW = $clog2(BLANK_CYC + 1);

    logic [NOUT-1:0] any_chain;
    logic [BW-1:0]   cnt_q;

    // OR-reduce the per-output strobes through a generated chain.
    genvar g;
    generate
        for (g = 0; g < NOUT; g++) begin : g_or
            if (g == 0) begin : g_first
                assign any_chain[g] = strobe[g];
            end else begin : g_next
                assign any_chain[g] = any_chain[g-1] | strobe[g];
            end
        end
    endgenerate

    // Load on a transition, count down otherwise, clear when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q <= '0;
        end else if (any_chain[NOUT-1]) begin
            cnt_q <= BW'(BLANK_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - BW'(1);
        end
    end

    assign blank = (cnt_q != '0);

endmodule

// File: rtl/curlim_offtime.sv
// Constant off-time sequencer with a regulation-rate floor.
// An accepted trip forces the bridge off for OFF_CYC cycles. The next trip is
// accepted no earlier than PERIOD_CYC cycles after the previous start.
// Assumes PERIOD_CYC > OFF_CYC.
module curlim_offtime #(
    parameter int unsigned OFF_CYC    = 2000,
    parameter int unsigned PERIOD_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic trip_ok,
    output logic force_off
);
    import curlim_pkg::*;

    localparam int unsigned OW = $clog2(OFF_CYC);
    localparam int unsigned PW = $clog2(PERIOD_CYC);

    ot_state_e     state_q, state_d;
    logic [OW-1:0] off_q, off_d;
    logic [PW-1:0] per_q, per_d;
    logic          start;

    // A trip starts an off-time when idle, or when the rate floor has run out.
    assign start = trip_ok && ((state_q == OT_IDLE) ||
                               (state_q == OT_HOLD && per_q == '0));

    // Next-state and counter update logic.
    always_comb begin
        state_d = state_q;
        off_d   = off_q;
        per_d   = (per_q != '0) ? per_q - PW'(1) : per_q;
        if (start) begin
            state_d = OT_OFF;
            off_d   = OW'(OFF_CYC - 1);
            per_d   = PW'(PERIOD_CYC - 1);
        end else begin
            case (state_q)
                OT_OFF: begin
                    if (off_q == '0) state_d = OT_HOLD;
                    else             off_d   = off_q - OW'(1);
                end
                OT_HOLD: begin
                    if (per_q == '0) state_d = OT_IDLE;
                end
                default: state_d = OT_IDLE;
            endcase
        end
    end

    // State registers; a disable returns everything to idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state_q <= OT_IDLE;
            off_q   <= '0;
            per_q   <= '0;
        end else begin
            state_q <= state_d;
            off_q   <= off_d;
            per_q   <= per_d;
        end
    end

    assign force_off = (state_q == OT_OFF);

endmodule

// File: rtl/curlim_short.sv
// Short-circuit detect inside the blanking window.
// Emits one registered pulse on each new qualified trip.
module curlim_short (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic blank,
    input  logic short_trip,
    output logic short_fault
);
    logic qual, qual_q;

    assign qual = enable && blank && short_trip;

    // Edge-detect the qualified trip into a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual_q      <= 1'b0;
            short_fault <= 1'b0;
        end else begin
            qual_q      <= qual;
            short_fault <= qual && !qual_q;
        end
    end

endmodule

// File: rtl/curlim_top.sv
// Constant off-time current limiter for an H-bridge.
// Combines the blanking timer, the off-time sequencer and short detection,
// and registers the foldback threshold select. Assumes all inputs are
// already synchronous to clk.
module curlim_top #(
    parameter int unsigned NOUT     = 2,
    parameter int unsigned CLK_MHZ  = 100,
    parameter int unsigned OFF_US   = 20,
    parameter int unsigned BLANK_US = 16,
    parameter int unsigned RATE_KHZ = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bridge_en,
    input  logic [NOUT-1:0] out_edge,
    input  logic            lim_trip,
    input  logic            short_trip,
    input  logic            hot_zone,
    output logic            force_off,
    output logic            short_fault,
    output logic            thr_low
);
    import curlim_pkg::*;

    localparam int unsigned OFF_CYC    = us_to_cycles(CLK_MHZ, OFF_US);
    localparam int unsigned BLANK_CYC  = us_to_cycles(CLK_MHZ, BLANK_US);
    localparam int unsigned PERIOD_CYC = rate_to_cycles(CLK_MHZ, RATE_KHZ);

    logic blank;
    logic trip_ok;

    curlim_blank #(.NOUT(NOUT), .BLANK_CYC(BLANK_CYC)) u_blank (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (bridge_en),
        .strobe (out_edge),
        .blank  (blank)
    );

    assign trip_ok = bridge_en && lim_trip && !blank;

    curlim_offtime #(.OFF_CYC(OFF_CYC), .PERIOD_CYC(PERIOD_CYC)) u_off (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (bridge_en),
        .trip_ok   (trip_ok),
        .force_off (force_off)
    );

    curlim_short u_short (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (bridge_en),
        .blank       (blank),
        .short_trip  (short_trip),
        .short_fault (short_fault)
    );

    // Register the foldback flag as the threshold select.
    always_ff @(posedge clk) begin
        if (!rst_n) thr_low <= 1'b0;
        else        thr_low <= hot_zone;
    end

endmodule

// File: rtl/curlim_checker.sv
// Port-level properties of the current limiter, bound to curlim_top.
module curlim_checker #(
    parameter int unsigned CLK_MHZ  = 100,
    parameter int unsigned OFF_US   = 20,
    parameter int unsigned RATE_KHZ = 20
) (
    input logic clk,
    input logic rst_n,
    input logic bridge_en,
    input logic lim_trip,
    input logic short_trip,
    input logic hot_zone,
    input logic force_off,
    input logic short_fault,
    input logic thr_low
);
    localparam int unsigned OFF_N = CLK_MHZ * OFF_US;
    localparam int unsigned PER_N = (CLK_MHZ * 1000) / RATE_KHZ;

    int unsigned run_q;
    int unsigned gap_q;

    // Length of the current force_off run.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 0;
        else        run_q <= force_off ? run_q + 1 : 0;
    end

    // Cycles since the last off-time start, saturating; a disable resets the floor.
    always_ff @(posedge clk) begin
        if (!rst_n || !bridge_en)            gap_q <= PER_N;
        else if (force_off && run_q == 0)    gap_q <= 1;
        else if (gap_q < PER_N)              gap_q <= gap_q + 1;
    end

    // R2
    off_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(force_off) && $past(bridge_en)) |-> run_q == OFF_N);

    // R3
    off_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |-> run_q < OFF_N);

    // R2
    off_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_off) |-> ($past(lim_trip) && $past(bridge_en)));

    // R7
    rate_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_off) |-> gap_q >= PER_N);

    // R5
    short_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        short_fault |=> !short_fault);

    // R5
    short_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        short_fault |-> ($past(short_trip) && $past(bridge_en)));

    // R8
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bridge_en |=> (!force_off && !short_fault));

    // R6
    thr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> thr_low == $past(hot_zone));

endmodule

bind curlim_top curlim_checker #(
    .CLK_MHZ  (CLK_MHZ),
    .OFF_US   (OFF_US),
    .RATE_KHZ (RATE_KHZ)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bridge_en   (bridge_en),
    .lim_trip    (lim_trip),
    .short_trip  (short_trip),
    .hot_zone    (hot_zone),
    .force_off   (force_off),
    .short_fault (short_fault),
    .thr_low     (thr_low)
);

// File: tb/curlim_top_test.sv
module curlim_top_test;
    localparam int OFF_EXP   = 100 * 20;
    localparam int BLANK_EXP = 100 * 16;
    localparam int PER_EXP   = 100000 / 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bridge_en = 1'b0;
    logic [1:0] out_edge = 2'b00;
    logic       lim_trip = 1'b0;
    logic       short_trip = 1'b0;
    logic       hot_zone = 1'b0;
    logic       force_off, short_fault, thr_low;

    int checks = 0;
    int errors = 0;

    curlim_top uut (
        .clk(clk), .rst_n(rst_n), .bridge_en(bridge_en), .out_edge(out_edge),
        .lim_trip(lim_trip), .short_trip(short_trip), .hot_zone(hot_zone),
        .force_off(force_off), .short_fault(short_fault), .thr_low(thr_low)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Disable for one cycle then re-enable, leaving all timers idle.
    task automatic go_idle();
        @(negedge clk);
        lim_trip = 0; short_trip = 0; out_edge = 0; bridge_en = 0;
        @(negedge clk);
        bridge_en = 1;
        @(negedge clk);
    endtask

    // Count consecutive force_off=1 samples, first one already seen.
    task automatic run_len(output int n);
        n = 1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (force_off) n++;
            else break;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 force_off in reset", force_off, 0);
        chk("R1 short_fault in reset", short_fault, 0);
        chk("R1 thr_low in reset", thr_low, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 force_off after reset", force_off, 0);
    endtask

    task automatic t_offtime();
        int n;
        go_idle();
        lim_trip = 1;
        @(negedge clk);
        lim_trip = 0;
        chk("R2 force_off next cycle", force_off, 1);
        run_len(n);
        chk("R2 off-time length", n, OFF_EXP);
    endtask

    task automatic t_retrig();
        int n, hi;
        go_idle();
        lim_trip = 1;
        @(negedge clk);
        n = 1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            lim_trip = (i % 3) != 0;
            if (force_off) n++;
            else break;
        end
        chk("R3 off-time not extended", n, OFF_EXP);
        lim_trip = 1;
        hi = 0;
        repeat (100) begin
            @(negedge clk);
            if (force_off) hi++;
        end
        chk("R3 no restart right after off-time", hi, 0);
        lim_trip = 0;
    endtask

    task automatic t_rate();
        int gap;
        go_idle();
        lim_trip = 1;
        @(negedge clk);
        chk("R7 first start", force_off, 1);
        gap = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            gap++;
            if (force_off && gap > OFF_EXP) break;
        end
        chk("R7 start spacing", gap, PER_EXP);
        lim_trip = 0;
    endtask

    task automatic blank_window(input string req, input logic [1:0] which);
        int hi;
        out_edge = which;
        @(negedge clk);
        out_edge = 0;
        lim_trip = 1;
        hi = 0;
        repeat (BLANK_EXP) begin
            @(negedge clk);
            if (force_off) hi++;
        end
        chk({req, " trips ignored while blanked"}, hi, 0);
        @(negedge clk);
        chk({req, " trip accepted after window"}, force_off, 1);
        lim_trip = 0;
    endtask

    task automatic t_blank();
        go_idle();
        blank_window("R4 out0", 2'b01);
        go_idle();
        out_edge = 2'b10;
        @(negedge clk);
        out_edge = 0;
        repeat (1000) @(negedge clk);
        blank_window("R4 restart", 2'b01);
    endtask

    task automatic t_short();
        int p;
        go_idle();
        out_edge = 2'b10;
        @(negedge clk);
        out_edge = 0;
        short_trip = 1;
        @(negedge clk);
        chk("R5 short pulse in window", short_fault, 1);
        p = 0;
        repeat (50) begin
            @(negedge clk);
            if (short_fault) p++;
        end
        chk("R5 single pulse while held", p, 0);
        short_trip = 0;
        go_idle();
        short_trip = 1;
        p = 0;
        repeat (30) begin
            @(negedge clk);
            if (short_fault) p++;
        end
        chk("R5 no pulse outside window", p, 0);
        short_trip = 0;
    endtask

    task automatic t_fold();
        @(negedge clk);
        hot_zone = 1;
        @(negedge clk);
        chk("R6 reduced threshold", thr_low, 1);
        hot_zone = 0;
        @(negedge clk);
        chk("R6 normal threshold", thr_low, 0);
    endtask

    task automatic t_disable();
        go_idle();
        lim_trip = 1;
        @(negedge clk);
        lim_trip = 0;
        repeat (10) @(negedge clk);
        bridge_en = 0;
        @(negedge clk);
        chk("R8 disable ends off-time", force_off, 0);
        bridge_en = 1;
        lim_trip = 1;
        @(negedge clk);
        chk("R8 immediate start after re-enable", force_off, 1);
        lim_trip = 0;
        go_idle();
        out_edge = 2'b01;
        @(negedge clk);
        out_edge = 0;
        bridge_en = 0;
        @(negedge clk);
        bridge_en = 1;
        lim_trip = 1;
        @(negedge clk);
        chk("R8 disable cancels blanking", force_off, 1);
        lim_trip = 0;
    endtask

    task automatic t_dis_inputs();
        int hi, p;
        go_idle();
        bridge_en = 0;
        out_edge = 2'b11;
        lim_trip = 1;
        short_trip = 1;
        hi = 0; p = 0;
        repeat (20) begin
            @(negedge clk);
            if (force_off) hi++;
            if (short_fault) p++;
        end
        chk("R9 lim_trip ignored when disabled", hi, 0);
        chk("R9 short_trip ignored when disabled", p, 0);
        out_edge = 0; lim_trip = 0; short_trip = 0;
        bridge_en = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_offtime();
        t_retrig();
        t_rate();
        t_blank();
        t_short();
        t_fold();
        t_disable();
        t_dis_inputs();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule